// File: doc/BRIEF.md
# Pipeline Operand Forwarding and Load-Use Interlock

This block sits beside the decode and execute stages of a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). For each of the two ALU operands of the instruction in execute, it picks the source of the operand. The source is the register file value, the ALU result held in the execute/memory pipeline register, or the value held in the memory/writeback register, which carries load data. The choice is made by comparing the execute-stage source register numbers with the destination numbers and write enables of the two later stages.

The register file is read only in decode and written only in writeback, and its write lands before its read in the same cycle. As a result only read-after-write dependences need handling, and a producer three slots ahead needs no bypass. There is one dependence that forwarding cannot cover: a load in execute whose destination is a source of the instruction in decode. In that case the block raises a stall, which holds the PC and the fetch/decode register, and a bubble, which turns the decode/execute entry into a no-op with its write enables cleared. The stall lasts one cycle. After that cycle the load has moved to the memory/writeback register and its data is forwarded from there.

The block is purely combinational from its data ports to its outputs. Its clock and reset serve only the embedded checks.

Top module: `fwd_interlock_unit`

## Requirements
- R1: When the memory-stage entry has write enable set, is not a load, and has a nonzero destination equal to an execute-stage source, that operand's select is 1 (execute/memory ALU result).
- R2: When R1 does not apply and the writeback-stage entry has write enable set with a nonzero destination equal to the source, that operand's select is 2 (memory/writeback value, including load data).
- R3: When both later stages would supply the same source, the younger memory-stage ALU result wins and the select is 1.
- R4: A source of register 0 always selects 0 (register file), whatever the later stages hold.
- R5: A later-stage entry with write enable cleared is never a forwarding source, even when its destination matches.
- R6: When the execute-stage entry is a load with write enable set and a nonzero destination equal to either decode-stage source, stall and bubble are both 1 in that same cycle.
- R7: Stall and bubble are 0 when the execute-stage producer is not a load, targets register 0, has write enable cleared, or matches neither decode source.
- R8: A load sitting in the memory stage is never forwarded through the ALU-result path (select 1).
- R9: With no matching later-stage writer, the select is 0, so a producer three slots ahead is read through the register file's write-before-read behaviour. Operands A and B are decided independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| dec_src_a | input | 5 | First source register of the instruction in decode |
| dec_src_b | input | 5 | Second source register of the instruction in decode |
| exe_src_a | input | 5 | First source register of the instruction in execute |
| exe_src_b | input | 5 | Second source register of the instruction in execute |
| exe_dst | input | 5 | Destination register of the instruction in execute |
| exe_wr | input | 1 | Write enable of the instruction in execute |
| exe_ld | input | 1 | Instruction in execute is a load |
| mem_dst | input | 5 | Destination held in the execute/memory register |
| mem_wr | input | 1 | Write enable held in the execute/memory register |
| mem_ld | input | 1 | Entry in the execute/memory register is a load |
| wbk_dst | input | 5 | Destination held in the memory/writeback register |
| wbk_wr | input | 1 | Write enable held in the memory/writeback register |
| opa_sel | output | 2 | Operand A source: 0 register file, 1 ALU result, 2 writeback value |
| opb_sel | output | 2 | Operand B source, same encoding |
| hold | output | 1 | Stall: hold PC and fetch/decode register |
| bubble | output | 1 | Insert a no-op into the decode/execute register |

## Verification
The hardest case to produce is a single source that both later stages claim at once. Reaching it through a pipeline needs two back-to-back writers of the same register, and it must be kept apart from a load sitting in the memory stage, which has to fall through to the older writer. The bench drives the stage fields directly so that each of these overlaps appears on its own. It places the contested register on one operand and a different one on the other, so a swap of operands or of priorities shows up. Load-use is driven on each decode source separately and also with a register-0 destination.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
   typedef enum logic [1:0] {
      SRC_REGFILE = 2'd0,
      SRC_ALU_RES = 2'd1,
      SRC_WB_VAL  = 2'd2
   } opnd_src_e;
endpackage

// File: rtl/fwd_src_select.sv
module fwd_src_select
   import fwd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] src,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic             mem_ld,
   input  logic [REG_W-1:0] wbk_dst,
   input  logic             wbk_wr,
   output opnd_src_e        sel
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;

   logic src_live;
   logic hit_mem;
   logic hit_wbk;

   generate
      if (ZERO_HARD) begin : g_zero_reg
         assign src_live = (src != ZERO_IDX);
      end else begin : g_no_zero_reg
         assign src_live = 1'b1;
      end
   endgenerate

   assign hit_mem = src_live && mem_wr && !mem_ld && (mem_dst == src);
   assign hit_wbk = src_live && wbk_wr && (wbk_dst == src);

   always_comb begin
      if (hit_mem)      sel = SRC_ALU_RES;
      else if (hit_wbk) sel = SRC_WB_VAL;
      else              sel = SRC_REGFILE;
   end

   assert_zero_reg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HARD && src == ZERO_IDX) |-> sel == SRC_REGFILE);
   assert_no_load_alu_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_ALU_RES) |-> (!mem_ld && mem_wr));
   assert_wb_needs_wr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SRC_WB_VAL) |-> (wbk_wr && wbk_dst == src));
   assert_legal_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sel != 2'd3);
endmodule

// File: rtl/fwd_load_use_detect.sv
module fwd_load_use_detect #(
   parameter int REG_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   input  logic [REG_W-1:0] exe_dst,
   input  logic             exe_wr,
   input  logic             exe_ld,
   output logic             hold,
   output logic             bubble
);
   localparam logic [REG_W-1:0] ZERO_IDX = '0;

   logic ld_live;
   logic dep_a;
   logic dep_b;

   assign ld_live = exe_wr && exe_ld && (exe_dst != ZERO_IDX);
   assign dep_a   = (dec_src_a == exe_dst);
   assign dep_b   = (dec_src_b == exe_dst);
   assign hold    = ld_live && (dep_a || dep_b);
   assign bubble  = hold;

   assert_stall_only_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      hold |-> (exe_ld && exe_wr && exe_dst != ZERO_IDX));
   assert_stall_bubble_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hold == bubble);
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
   import fwd_pkg::*;
#(
   parameter int REG_W     = 5,
   parameter bit ZERO_HARD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] dec_src_a,
   input  logic [REG_W-1:0] dec_src_b,
   input  logic [REG_W-1:0] exe_src_a,
   input  logic [REG_W-1:0] exe_src_b,
   input  logic [REG_W-1:0] exe_dst,
   input  logic             exe_wr,
   input  logic             exe_ld,
   input  logic [REG_W-1:0] mem_dst,
   input  logic             mem_wr,
   input  logic             mem_ld,
   input  logic [REG_W-1:0] wbk_dst,
   input  logic             wbk_wr,
   output logic [1:0]       opa_sel,
   output logic [1:0]       opb_sel,
   output logic             hold,
   output logic             bubble
);
   localparam int NUM_OPND = 2;

   if (REG_W < 1 || REG_W > 8) begin : g_bad_width
      $error("fwd_interlock_unit: REG_W out of range");
   end

   logic [REG_W-1:0] opnd_src [NUM_OPND];
   opnd_src_e        opnd_sel [NUM_OPND];

   assign opnd_src[0] = exe_src_a;
   assign opnd_src[1] = exe_src_b;

   for (genvar i = 0; i < NUM_OPND; i++) begin : g_opnd
      fwd_src_select #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_sel (
         .clk     (clk),
         .rst_n   (rst_n),
         .src     (opnd_src[i]),
         .mem_dst (mem_dst),
         .mem_wr  (mem_wr),
         .mem_ld  (mem_ld),
         .wbk_dst (wbk_dst),
         .wbk_wr  (wbk_wr),
         .sel     (opnd_sel[i])
      );
   end

   assign opa_sel = opnd_sel[0];
   assign opb_sel = opnd_sel[1];

   fwd_load_use_detect #(.REG_W(REG_W)) u_ldu (
      .clk       (clk),
      .rst_n     (rst_n),
      .dec_src_a (dec_src_a),
      .dec_src_b (dec_src_b),
      .exe_dst   (exe_dst),
      .exe_wr    (exe_wr),
      .exe_ld    (exe_ld),
      .hold      (hold),
      .bubble    (bubble)
   );

   assert_younger_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_ld && mem_dst == exe_src_a && exe_src_a != '0) |-> opa_sel == 2'd1);
   assert_fwd_alu_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (opb_sel == 2'd1) |-> (mem_dst == exe_src_b && exe_src_b != '0));
endmodule

// File: tb/sim_fwd_interlock_unit.sv
module sim_fwd_interlock_unit;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] dec_src_a = '0, dec_src_b = '0;
   logic [4:0] exe_src_a = '0, exe_src_b = '0, exe_dst = '0;
   logic       exe_wr = 1'b0, exe_ld = 1'b0;
   logic [4:0] mem_dst = '0, wbk_dst = '0;
   logic       mem_wr = 1'b0, mem_ld = 1'b0, wbk_wr = 1'b0;
   logic [1:0] opa_sel, opb_sel;
   logic       hold, bubble;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   fwd_interlock_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
      .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
      .exe_dst(exe_dst), .exe_wr(exe_wr), .exe_ld(exe_ld),
      .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_ld(mem_ld),
      .wbk_dst(wbk_dst), .wbk_wr(wbk_wr),
      .opa_sel(opa_sel), .opb_sel(opb_sel), .hold(hold), .bubble(bubble)
   );

   task automatic expect_out(input string req, input logic [1:0] ea, input logic [1:0] eb,
                             input logic es);
      checks++;
      if (opa_sel !== ea || opb_sel !== eb || hold !== es || bubble !== es) begin
         errors++;
         $display("FAIL %s: got a=%0d b=%0d stall=%0b bubble=%0b, expected a=%0d b=%0d stall=%0b bubble=%0b",
                  req, opa_sel, opb_sel, hold, bubble, ea, eb, es, es);
      end
   endtask

   task automatic drive(input logic [4:0] da, input logic [4:0] db,
                        input logic [4:0] xa, input logic [4:0] xb,
                        input logic [4:0] xd, input logic xw, input logic xl,
                        input logic [4:0] md, input logic mw, input logic ml,
                        input logic [4:0] wd, input logic ww);
      @(negedge clk);
      dec_src_a = da; dec_src_b = db; exe_src_a = xa; exe_src_b = xb;
      exe_dst = xd; exe_wr = xw; exe_ld = xl;
      mem_dst = md; mem_wr = mw; mem_ld = ml; wbk_dst = wd; wbk_wr = ww;
      #1;
   endtask

   task automatic t_reset;
      drive(0,0,0,0,0,0,0,0,0,0,0,0);
      expect_out("R9 reset idle", 2'd0, 2'd0, 1'b0);
   endtask

   task automatic t_alu_fwd;
      drive(0,0,5,6,0,0,0,5,1,0,0,0);
      expect_out("R1 alu to A", 2'd1, 2'd0, 1'b0);
      drive(0,0,7,9,0,0,0,9,1,0,0,0);
      expect_out("R1 alu to B", 2'd0, 2'd1, 1'b0);
   endtask

   task automatic t_wb_fwd;
      drive(0,0,3,12,0,0,0,0,0,0,12,1);
      expect_out("R2 wb to B", 2'd0, 2'd2, 1'b0);
      drive(0,0,31,31,0,0,0,4,1,0,31,1);
      expect_out("R2 wb to both", 2'd2, 2'd2, 1'b0);
   endtask

   task automatic t_priority;
      drive(0,0,8,10,0,0,0,8,1,0,8,1);
      expect_out("R3 younger wins A", 2'd1, 2'd0, 1'b0);
      drive(0,0,11,10,0,0,0,10,1,0,11,1);
      expect_out("R3 split sources", 2'd2, 2'd1, 1'b0);
   endtask

   task automatic t_zero;
      drive(0,0,0,0,0,0,0,0,1,0,0,1);
      expect_out("R4 register 0", 2'd0, 2'd0, 1'b0);
   endtask

   task automatic t_no_wr;
      drive(0,0,6,6,0,0,0,6,0,0,6,0);
      expect_out("R5 write enable clear", 2'd0, 2'd0, 1'b0);
   endtask

   task automatic t_load_use;
      drive(14,2,0,0,14,1,1,0,0,0,0,0);
      expect_out("R6 load-use A", 2'd0, 2'd0, 1'b1);
      drive(1,20,0,0,20,1,1,0,0,0,0,0);
      expect_out("R6 load-use B", 2'd0, 2'd0, 1'b1);
   endtask

   task automatic t_no_stall;
      drive(14,2,0,0,14,1,0,0,0,0,0,0);
      expect_out("R7 alu producer", 2'd0, 2'd0, 1'b0);
      drive(0,0,0,0,0,1,1,0,0,0,0,0);
      expect_out("R7 load to r0", 2'd0, 2'd0, 1'b0);
      drive(3,4,0,0,5,1,1,0,0,0,0,0);
      expect_out("R7 independent load", 2'd0, 2'd0, 1'b0);
      drive(5,5,0,0,5,0,1,0,0,0,0,0);
      expect_out("R7 load no write", 2'd0, 2'd0, 1'b0);
   endtask

   task automatic t_mem_load;
      drive(0,0,13,13,0,0,0,13,1,1,0,0);
      expect_out("R8 load in memory stage", 2'd0, 2'd0, 1'b0);
      drive(0,0,13,2,0,0,0,13,1,1,13,1);
      expect_out("R8 falls to older writer", 2'd2, 2'd0, 1'b0);
   endtask

   task automatic t_distance3;
      drive(0,0,17,18,0,0,0,19,1,0,20,1);
      expect_out("R9 regfile path", 2'd0, 2'd0, 1'b0);
   endtask

   initial begin
      #(4*100000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk); rst_n = 1'b1;
      t_alu_fwd();
      t_wb_fwd();
      t_priority();
      t_zero();
      t_no_wr();
      t_load_use();
      t_no_stall();
      t_mem_load();
      t_distance3();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule